// File: doc/BRIEF.md
# Configurable Fixed-Point Requantizer

This block takes one wide fixed-point word per cycle and rewrites it in a narrower fixed-point format. Input and output word widths and fraction-bit counts are compile-time parameters. The output may not have more fraction bits than the input. The signedness of each side is also a parameter. Two select inputs, sampled with each word, choose one of seven rounding rules and one of four overflow rules.

The work happens in a fixed order. The input is first taken without any loss. The surplus fraction bits are then removed under the chosen rounding rule. This step works on a widened word, so a carry produced by rounding is kept. Last, the overflow rule fits the rounded value into the output word.

The result is registered together with a valid bit and two flags. One flag reports that bits were lost in rounding. The other reports that the rounded value fell outside the output range. A typical use is after an adder, a multiplier or an accumulator, where a full-width sum must be narrowed before it is passed on.

Top module: `fxq_requant`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_data`, `q_flag` and `ovf_flag` are all 0.
- R2: `out_valid` equals the value `in_valid` had at the previous rising edge. `out_data`, `q_flag` and `ovf_flag` take the result of a word one cycle after it is accepted with `in_valid` high. They hold their values while `in_valid` is low.
- R3: `q_mode` 0 (the default) truncates toward minus infinity. With an input of 4 fraction bits and an output of 2 fraction bits, the input 3.3125 (raw 53) gives 3.25 (raw 13).
- R4: `q_mode` 1 truncates toward zero. A negative value with nonzero discarded bits moves one output LSB up from its floor.
- R5: `q_mode` 2 to 6 round to the nearest output value, and differ only on an exact half:
  - mode 2 resolves the half away from zero;
  - mode 3 resolves it upward;
  - mode 4 resolves it downward;
  - mode 5 resolves it to an even LSB;
  - mode 6 resolves it toward zero.
- R6: `q_mode` 7 behaves exactly as mode 0.
- R7: `q_flag` is 1 exactly when at least one discarded fraction bit of the input was nonzero.
- R8: `ovf_flag` is 1 exactly when the rounded value, including any rounding carry, lies outside the output range. When it is 0, `out_data` is the rounded value under every overflow mode.
- R9: `o_mode` 0 (the default) wraps: `out_data` is the low output-width bits of the rounded value. For a 6-bit signed output, a rounded value of 100 gives -28.
- R10: With `o_mode` 1 and an overflow, `out_data` is the output maximum for a value that is too large, and the output minimum for a value that is too small.
- R11: With `o_mode` 2 and an overflow, `out_data` is 0.
- R12: With `o_mode` 3, a signed output, and an overflow, the result has the sign of the rounded value. Its magnitude is the rounded magnitude modulo 2^(OUT_W-1).
- R13: For an unsigned output, the range is 0 to 2^OUT_W-1 and every negative rounded value is an overflow. Saturation clamps such a value to 0. Overflow mode 3 gives the magnitude modulo 2^OUT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word is present this cycle |
| in_data | input | IN_W | Wide fixed-point input, IN_F fraction bits |
| q_mode | input | 3 | Rounding rule select (R3 to R6) |
| o_mode | input | 2 | Overflow rule select (R9 to R12) |
| out_valid | output | 1 | Registered valid |
| out_data | output | OUT_W | Registered result, OUT_F fraction bits |
| q_flag | output | 1 | Discarded fraction bits were nonzero |
| ovf_flag | output | 1 | Rounded value was outside the output range |

## Verification
The bench sweeps every 10-bit input word against every pair of rounding and overflow modes, on a signed output and on an unsigned output at the same time. Each result is compared with a reference computed from integer floor division and remainder.

The full input sweep places every possible remainder next to both positive and negative floors. This separates the tie rules of the five nearest modes from one another, and separates both truncations from all of them. Values near both ends of the input range drive rounding carries across the output limits, so wrap, saturate, zero and sign-magnitude results can be told apart. The unsigned copy confirms that negative values are treated as overflow. Directed words cover the two worked examples and the hold behaviour when no word is offered.

// File: rtl/fxq_pkg.sv
package fxq_pkg;

  typedef enum logic [2:0] {
    QM_TRUNC     = 3'd0,
    QM_TRUNC_Z   = 3'd1,
    QM_NEAR_AWAY = 3'd2,
    QM_NEAR_UP   = 3'd3,
    QM_NEAR_DOWN = 3'd4,
    QM_NEAR_EVEN = 3'd5,
    QM_NEAR_ZERO = 3'd6
  } qmode_e;

  typedef enum logic [1:0] {
    OM_WRAP = 2'd0,
    OM_SAT  = 2'd1,
    OM_ZERO = 2'd2,
    OM_SMAG = 2'd3
  } omode_e;

  // Decide whether the floored value must move up by one output LSB.
  // neg  : input is negative
  // half : discarded bits have their top bit set
  // rest : any discarded bit below the top one is set
  // lsb  : LSB of the floored value
  function automatic logic round_inc(input logic [2:0] mode,
                                     input logic neg,
                                     input logic half,
                                     input logic rest,
                                     input logic lsb);
    logic above_half;
    logic exact_half;
    logic res;
    above_half = half & rest;
    exact_half = half & ~rest;
    case (mode)
      QM_TRUNC_Z:   res = neg & (half | rest);
      QM_NEAR_AWAY: res = above_half | (exact_half & ~neg);
      QM_NEAR_UP:   res = half;
      QM_NEAR_DOWN: res = above_half;
      QM_NEAR_EVEN: res = above_half | (exact_half & lsb);
      QM_NEAR_ZERO: res = above_half | (exact_half & neg);
      default:      res = 1'b0;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/fxq_quantize.sv
module fxq_quantize #(
  parameter int IN_W      = 10,
  parameter int SH        = 2,
  parameter bit IN_SIGNED = 1'b1,
  parameter int QW        = IN_W - SH + 2
) (
  input  logic [IN_W-1:0]        din,
  input  logic [2:0]             qmode,
  output logic signed [QW-1:0]   qval,
  output logic                   nz,
  output logic                   inc,
  output logic                   neg
);

  localparam int EW = IN_W + 1;

  logic signed [EW-1:0] ext;

  assign ext = IN_SIGNED ? {din[IN_W-1], din} : {1'b0, din};
  assign neg = ext[EW-1];

  generate
    if (SH == 0) begin : g_noshift
      assign nz   = 1'b0;
      assign inc  = 1'b0;
      assign qval = {{(QW-EW){ext[EW-1]}}, ext};
    end else begin : g_shift
      localparam int FW = EW - SH;
      logic signed [FW-1:0] fl;
      logic [SH-1:0]        rem;
      logic [SH-1:0]        top_bit;
      logic                 half;
      logic                 rest;

      assign fl      = ext[EW-1:SH];
      assign rem     = ext[SH-1:0];
      assign top_bit = SH'(1) << (SH - 1);
      assign half    = rem[SH-1];
      assign rest    = (rem & ~top_bit) != '0;
      assign nz      = rem != '0;
      assign inc     = fxq_pkg::round_inc(qmode, neg, half, rest, fl[0]);
      assign qval    = $signed({fl[FW-1], fl}) + $signed({{(QW-1){1'b0}}, inc});
    end
  endgenerate

endmodule

// File: rtl/fxq_overflow.sv
module fxq_overflow #(
  parameter int QW         = 10,
  parameter int OUT_W      = 6,
  parameter bit OUT_SIGNED = 1'b1,
  parameter int CW         = 10
) (
  input  logic signed [QW-1:0] qval,
  input  logic [1:0]           omode,
  output logic [OUT_W-1:0]     dout,
  output logic                 ovf,
  output logic                 too_hi,
  output logic                 too_lo
);

  localparam logic signed [CW-1:0] MAXV = OUT_SIGNED ?
      CW'((64'sd1 <<< (OUT_W - 1)) - 64'sd1) : CW'((64'sd1 <<< OUT_W) - 64'sd1);
  localparam logic signed [CW-1:0] MINV = OUT_SIGNED ?
      CW'(-(64'sd1 <<< (OUT_W - 1))) : '0;

  logic signed [CW-1:0] qc;
  logic [CW-1:0]        absq;
  logic                 qneg;
  logic [OUT_W-1:0]     low;
  logic [OUT_W-1:0]     smw;

  assign qc     = CW'(qval);
  assign qneg   = qc[CW-1];
  assign absq   = qneg ? -qc : qc;
  assign low    = qc[OUT_W-1:0];
  assign too_hi = qc > MAXV;
  assign too_lo = qc < MINV;
  assign ovf    = too_hi | too_lo;

  generate
    if (OUT_SIGNED) begin : g_sm_signed
      logic [OUT_W-1:0] mag;
      assign mag = {1'b0, absq[OUT_W-2:0]};
      assign smw = qneg ? -mag : mag;
    end else begin : g_sm_unsigned
      assign smw = absq[OUT_W-1:0];
    end
  endgenerate

  always_comb begin
    case (omode)
      fxq_pkg::OM_SAT:  dout = ovf ? (too_hi ? MAXV[OUT_W-1:0] : MINV[OUT_W-1:0]) : low;
      fxq_pkg::OM_ZERO: dout = ovf ? '0 : low;
      fxq_pkg::OM_SMAG: dout = ovf ? smw : low;
      default:          dout = low;
    endcase
  end

endmodule

// File: rtl/fxq_requant.sv
module fxq_requant #(
  parameter int IN_W       = 10,
  parameter int IN_F       = 4,
  parameter int OUT_W      = 6,
  parameter int OUT_F      = 2,
  parameter bit IN_SIGNED  = 1'b1,
  parameter bit OUT_SIGNED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  input  logic [2:0]       q_mode,
  input  logic [1:0]       o_mode,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  output logic             q_flag,
  output logic             ovf_flag
);

  localparam int SH = IN_F - OUT_F;
  localparam int QW = IN_W - SH + 2;
  localparam int CW = (QW > OUT_W + 2) ? QW : OUT_W + 2;
  localparam logic [OUT_W-1:0] MAXO = OUT_SIGNED ? {1'b0, {(OUT_W-1){1'b1}}} : '1;
  localparam logic [OUT_W-1:0] MINO = OUT_SIGNED ? {1'b1, {(OUT_W-1){1'b0}}} : '0;

  logic signed [QW-1:0] q_val;
  logic signed [CW-1:0] q_ext;
  logic                 q_nz;
  logic                 q_inc;
  logic                 in_neg;
  logic [OUT_W-1:0]     ov_dout;
  logic                 ov_any;
  logic                 ov_hi;
  logic                 ov_lo;

  fxq_quantize #(
    .IN_W(IN_W), .SH(SH), .IN_SIGNED(IN_SIGNED), .QW(QW)
  ) quant_i (
    .din(in_data), .qmode(q_mode), .qval(q_val),
    .nz(q_nz), .inc(q_inc), .neg(in_neg)
  );

  fxq_overflow #(
    .QW(QW), .OUT_W(OUT_W), .OUT_SIGNED(OUT_SIGNED), .CW(CW)
  ) ovf_i (
    .qval(q_val), .omode(o_mode), .dout(ov_dout),
    .ovf(ov_any), .too_hi(ov_hi), .too_lo(ov_lo)
  );

  assign q_ext = CW'(q_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      q_flag    <= 1'b0;
      ovf_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= ov_dout;
        q_flag   <= q_nz;
        ovf_flag <= ov_any;
      end
    end
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(q_flag) && $stable(ovf_flag))); // R2
  AST_EXACT_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !q_nz |-> !q_inc); // R7
  AST_IN_RANGE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ov_any) |=> (out_data == $past(q_ext[OUT_W-1:0]))); // R8
  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ov_hi && ov_lo)); // R8
  AST_SAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ov_any && o_mode == fxq_pkg::OM_SAT) |=>
    (out_data == MAXO || out_data == MINO)); // R10
  AST_ZERO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ov_any && o_mode == fxq_pkg::OM_ZERO) |=> (out_data == '0)); // R11
  AST_SM_POS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (OUT_SIGNED && in_valid && ov_hi && o_mode == fxq_pkg::OM_SMAG) |=>
    !out_data[OUT_W-1]); // R12
  AST_UNS_NEG_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (!OUT_SIGNED && in_valid && q_ext < 0) |-> ov_lo); // R13

endmodule

// File: tb/fxq_requant_tb.sv
`timescale 1ns/1ps
module fxq_requant_tb_top;

  localparam int IN_W = 10;
  localparam int OUT_W = 6;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [IN_W-1:0] in_data = '0;
  logic [2:0] q_mode = '0;
  logic [1:0] o_mode = '0;
  logic s_valid, s_qf, s_of, u_valid, u_qf, u_of;
  logic [OUT_W-1:0] s_data, u_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fxq_requant #(.OUT_SIGNED(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .q_mode(q_mode), .o_mode(o_mode), .out_valid(s_valid), .out_data(s_data),
    .q_flag(s_qf), .ovf_flag(s_of));

  fxq_requant #(.OUT_SIGNED(1'b0)) dut_u_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .q_mode(q_mode), .o_mode(o_mode), .out_valid(u_valid), .out_data(u_data),
    .q_flag(u_qf), .ovf_flag(u_of));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void model(input int x, input int qm, input int om, input bit osg,
                                output int y, output bit qf, output bit of);
    int fl, r, q, lo, hi, w, mag;
    bit up, neg;
    neg = x < 0;
    fl = (x >= 0) ? x / D : -((-x + D - 1) / D);
    r = x - fl * D;
    case (qm)
      1: up = neg && r != 0;
      2: up = (2*r > D) || (2*r == D && !neg);
      3: up = 2*r >= D;
      4: up = 2*r > D;
      5: up = (2*r > D) || (2*r == D && (fl % 2 != 0));
      6: up = (2*r > D) || (2*r == D && neg);
      default: up = 1'b0;
    endcase
    q = fl + (up ? 1 : 0);
    lo = osg ? -32 : 0;
    hi = osg ? 31 : 63;
    qf = r != 0;
    of = (q < lo) || (q > hi);
    w = ((q % 64) + 64) % 64;
    if (!of || om == 0) y = w;
    else if (om == 1) y = (q > hi) ? hi : lo;
    else if (om == 2) y = 0;
    else begin
      mag = (q < 0) ? -q : q;
      if (osg) begin
        mag = mag % 32;
        y = (q < 0) ? -mag : mag;
      end else y = mag % 64;
    end
    y = y & 63;
  endfunction

  function automatic string tag_for(input int qm, input int om, input bit of, input bit osg);
    if (!osg) return "R13";
    if (of && om == 1) return "R10";
    if (of && om == 2) return "R11";
    if (of && om == 3) return "R12";
    if (of) return "R9";
    case (qm)
      0: return "R3";
      1: return "R4";
      7: return "R6";
      default: return "R5";
    endcase
  endfunction

  int px, pqm, pom;
  bit have_prev = 1'b0;

  task automatic check_prev();
    int ys, yu;
    bit qs, os, qu, ou;
    model(px, pqm, pom, 1'b1, ys, qs, os);
    model(px, pqm, pom, 1'b0, yu, qu, ou);
    check("R2", int'(s_valid), 1);
    check(tag_for(pqm, pom, os, 1'b1), int'(s_data), ys);
    check("R7", int'(s_qf), int'(qs));
    check("R8", int'(s_of), int'(os));
    check(tag_for(pqm, pom, ou, 1'b0), int'(u_data), yu);
    check("R13", int'(u_of), int'(ou));
  endtask

  task automatic step(input int x, input int qm, input int om);
    @(negedge clk);
    if (have_prev) check_prev();
    in_valid = 1'b1;
    in_data = x[IN_W-1:0];
    q_mode = qm[2:0];
    o_mode = om[1:0];
    px = x; pqm = qm; pom = om;
    have_prev = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b1;
    in_data = 10'h155;
    q_mode = 3'd2;
    repeat (3) @(negedge clk);
    check("R1", int'(s_valid), 0);
    check("R1", int'(s_data), 0);
    check("R1", int'(s_qf | s_of), 0);
    check("R1", int'(u_valid | u_qf | u_of) + int'(u_data), 0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", int'(s_valid), 0);

    // R3 worked example: raw 53 (3.3125) truncates to raw 13 (3.25)
    step(53, 0, 0);
    @(negedge clk);
    check("R3", int'(s_data), 13);
    check("R7", int'(s_qf), 1);
    have_prev = 1'b0;
    // R9 worked example: value 100 in output units wraps to -28
    step(400, 0, 0);
    @(negedge clk);
    check("R9", int'(s_data), (-28) & 63);
    check("R8", int'(s_of), 1);
    have_prev = 1'b0;

    for (int qm = 0; qm < 8; qm++)
      for (int om = 0; om < 4; om++)
        for (int x = -512; x < 512; x++)
          step(x, qm, om);
    @(negedge clk);
    check_prev();
    have_prev = 1'b0;

    // R2 hold: no word offered, outputs keep the last result
    begin
      int hold_s, hold_u;
      hold_s = int'(s_data);
      hold_u = int'(u_data);
      in_valid = 1'b0;
      in_data = 10'h0AB;
      q_mode = 3'd3;
      o_mode = 2'd1;
      repeat (2) @(negedge clk);
      check("R2", int'(s_valid), 0);
      check("R2", int'(s_data), hold_s);
      check("R2", int'(u_data), hold_u);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule